// File: doc/BRIEF.md
# Guest Counter Access Gate

This block rules on every attempted read of the user-level counter CSRs: cycle, time, instret and the hardware performance counters 3 to 31. It takes the CSR address, the current privilege level, the virtualization flag and the three counter-enable vectors: machine, supervisor and the hypervisor one held locally. From these it produces a single verdict. Either the read goes ahead (`allow_o`), or it must trap as an illegal instruction (`illegal_o`). Addresses outside the counter window raise neither output, so that other CSR decode can handle them.

The hypervisor enable vector lives inside the block. Software writes it through a simple write-enable port, and its current value is visible on `hce_o`. A parameter mask names the bits that are hardwired to zero. Writes to those bits are dropped, so a guest read of the matching counter always traps.

Top module: `guest_cnt_gate`

## Requirements
- R1: After reset `hce_o` reads all zeros.
- R2: When `hce_we_i`=1 at a clock edge, `hce_o` afterwards equals `hce_wdata_i` with every bit set in `HW_ZERO_MASK` (default: bits 31..28) forced to 0. Masked bits never read as 1.
- R3: Addresses 0xC00..0xC1F and 0xC80..0xC9F are counter reads, with the enable-bit index equal to the address minus 0xC00 or 0xC80 (the low 5 bits). Any other address gives `allow_o`=0 and `illegal_o`=0.
- R4: With `priv_i`=3 (machine level), a counter read is always allowed, whatever the enables.
- R5: Below machine level, a clear machine-enable bit for the index makes the read illegal, whatever the other enables.
- R6: With `virt_i`=0 and `priv_i`=1 (supervisor, or the reserved value 2, treated as supervisor), the read is allowed exactly when the machine-enable bit is set.
- R7: With `virt_i`=0 and `priv_i`=0 (user), the read needs both the machine-enable bit and the supervisor-enable bit.
- R8: With `virt_i`=1 and supervisor-level `priv_i` (guest kernel), the read needs both the machine-enable bit and the `hce_o` bit.
- R9: With `virt_i`=1 and `priv_i`=0 (guest user), the read needs the machine-enable bit, the `hce_o` bit and the supervisor-enable bit.
- R10: For a counter address, exactly one of `allow_o` and `illegal_o` is 1. The outputs are combinational from the current inputs and `hce_o`.
- R11: A cycle with `hce_we_i`=0 leaves `hce_o` unchanged, whatever `hce_wdata_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_addr_i | input | 12 | CSR address of the read |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization mode flag |
| mcnt_en_i | input | 32 | Machine counter-enable vector |
| scnt_en_i | input | 32 | Supervisor counter-enable vector (guest copy when virt_i=1) |
| hce_we_i | input | 1 | Write strobe for the hypervisor enable vector |
| hce_wdata_i | input | 32 | Write data for the hypervisor enable vector |
| hce_o | output | 32 | Current hypervisor enable vector |
| allow_o | output | 1 | Counter read permitted |
| illegal_o | output | 1 | Counter read must raise illegal instruction |

## Verification
Random enable vectors paired with random privilege and virtualization values separate the four non-machine cases. A guest-user read that differs from a guest-kernel read only in the supervisor bit shows whether the supervisor enable is applied at the right level. Addresses are drawn from both counter windows, their edge addresses and the neighbours just outside them, which exposes off-by-one decode and a missing high-half window. Writes of all ones, and writes that try to set the hardwired bits, tell the masking apart from plain storage.

// File: rtl/guest_cnt_gate_pkg.sv
package guest_cnt_gate_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/cnt_addr_decode.sv
module cnt_addr_decode #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_CNT = 32,
  parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80,
  localparam int unsigned IDX_W = $clog2(NUM_CNT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_CNT);

  logic [ADDR_W-1:0] off_lo, off_hi;
  logic              hit_lo, hit_hi;

  assign off_lo = addr_i - LO_BASE;
  assign off_hi = addr_i - HI_BASE;
  assign hit_lo = off_lo < SPAN;
  assign hit_hi = off_hi < SPAN;

  assign hit_o = hit_lo | hit_hi;
  assign idx_o = hit_lo ? off_lo[IDX_W-1:0] : off_hi[IDX_W-1:0];
endmodule

// File: rtl/cnt_hce_reg.sv
module cnt_hce_reg #(
  parameter int unsigned NUM_CNT = 32,
  parameter logic [NUM_CNT-1:0] HW_ZERO_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_CNT-1:0] wdata_i,
  output logic [NUM_CNT-1:0] q_o
);
  for (genvar b = 0; b < NUM_CNT; b++) begin : g_bit
    if (HW_ZERO_MASK[b]) begin : g_tied
      assign q_o[b] = 1'b0;
    end else begin : g_flop
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   bit_q <= 1'b0;
        else if (we_i) bit_q <= wdata_i[b];
      end
      assign q_o[b] = bit_q;
    end
  end
endmodule

// File: rtl/cnt_gate_eval.sv
module cnt_gate_eval
  import guest_cnt_gate_pkg::*;
#(
  parameter int unsigned NUM_CNT = 32,
  localparam int unsigned IDX_W = $clog2(NUM_CNT)
) (
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  priv_e              priv_i,
  input  logic               virt_i,
  input  logic [NUM_CNT-1:0] mcnt_en_i,
  input  logic [NUM_CNT-1:0] scnt_en_i,
  input  logic [NUM_CNT-1:0] hcnt_en_i,
  output logic               allow_o,
  output logic               illegal_o
);
  logic m_ok, s_ok, h_ok, is_m, is_u, granted;

  assign m_ok = mcnt_en_i[idx_i];
  assign s_ok = scnt_en_i[idx_i];
  assign h_ok = hcnt_en_i[idx_i];
  assign is_m = (priv_i == PRIV_M);
  assign is_u = (priv_i == PRIV_U);

  always_comb begin
    if (is_m) begin
      granted = 1'b1;
    end else begin
      granted = m_ok;
      if (virt_i) granted = granted & h_ok;
      if (is_u)   granted = granted & s_ok;
    end
  end

  assign allow_o   = hit_i & granted;
  assign illegal_o = hit_i & ~granted;
endmodule

// File: rtl/guest_cnt_gate.sv
module guest_cnt_gate
  import guest_cnt_gate_pkg::*;
#(
  parameter int unsigned NUM_CNT = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80,
  parameter logic [NUM_CNT-1:0] HW_ZERO_MASK = NUM_CNT'(32'hF000_0000)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  csr_addr_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic [NUM_CNT-1:0] mcnt_en_i,
  input  logic [NUM_CNT-1:0] scnt_en_i,
  input  logic               hce_we_i,
  input  logic [NUM_CNT-1:0] hce_wdata_i,
  output logic [NUM_CNT-1:0] hce_o,
  output logic               allow_o,
  output logic               illegal_o
);
  localparam int unsigned IDX_W = $clog2(NUM_CNT);

  logic             hit;
  logic [IDX_W-1:0] idx;

  cnt_addr_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CNT(NUM_CNT),
    .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE)
  ) u_dec (
    .addr_i(csr_addr_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  cnt_hce_reg #(
    .NUM_CNT     (NUM_CNT),
    .HW_ZERO_MASK(HW_ZERO_MASK)
  ) u_hce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (hce_we_i),
    .wdata_i(hce_wdata_i),
    .q_o    (hce_o)
  );

  cnt_gate_eval #(
    .NUM_CNT(NUM_CNT)
  ) u_eval (
    .hit_i    (hit),
    .idx_i    (idx),
    .priv_i   (priv_e'(priv_i)),
    .virt_i   (virt_i),
    .mcnt_en_i(mcnt_en_i),
    .scnt_en_i(scnt_en_i),
    .hcnt_en_i(hce_o),
    .allow_o  (allow_o),
    .illegal_o(illegal_o)
  );
endmodule

// File: rtl/guest_cnt_gate_chk.sv
module guest_cnt_gate_chk #(
  parameter int unsigned NUM_CNT = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [NUM_CNT-1:0] HW_ZERO_MASK = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  csr_addr_i,
  input logic [1:0]         priv_i,
  input logic               virt_i,
  input logic [NUM_CNT-1:0] mcnt_en_i,
  input logic [NUM_CNT-1:0] scnt_en_i,
  input logic               hce_we_i,
  input logic [NUM_CNT-1:0] hce_wdata_i,
  input logic [NUM_CNT-1:0] hce_o,
  input logic               allow_o,
  input logic               illegal_o
);
  localparam int unsigned IDX_W = $clog2(NUM_CNT);
  logic [IDX_W-1:0] sel;
  assign sel = csr_addr_i[IDX_W-1:0];

  assert_write_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hce_we_i |=> hce_o == ($past(hce_wdata_i) & ~HW_ZERO_MASK));
  assert_tied_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hce_o & HW_ZERO_MASK) == '0);
  assert_machine_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'd3 && illegal_o) |-> 1'b0);
  assert_mgate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i != 2'd3 && allow_o) |-> mcnt_en_i[sel]);
  assert_hgate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (virt_i && priv_i != 2'd3 && allow_o) |-> hce_o[sel]);
  assert_vu_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (virt_i && priv_i == 2'd0 && allow_o) |-> (hce_o[sel] && scnt_en_i[sel]));
  assert_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(allow_o && illegal_o));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hce_we_i |=> $stable(hce_o));
endmodule

bind guest_cnt_gate guest_cnt_gate_chk #(
  .NUM_CNT     (NUM_CNT),
  .ADDR_W      (ADDR_W),
  .HW_ZERO_MASK(HW_ZERO_MASK)
) u_chk (.*);

// File: tb/guest_cnt_gate_tb_top.sv
module guest_cnt_gate_tb_top;
  localparam logic [31:0] MASK = 32'hF000_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  priv = '0;
  logic        virt = 1'b0;
  logic [31:0] mcnt = '0, scnt = '0, hwd = '0;
  logic        hwe = 1'b0;
  logic [31:0] hce;
  logic        allow, illegal;

  int checks = 0, fails = 0;
  logic [31:0] hce_model = '0;

  always #5 clk = ~clk;

  guest_cnt_gate dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .csr_addr_i(csr_addr), .priv_i(priv),
    .virt_i(virt), .mcnt_en_i(mcnt), .scnt_en_i(scnt), .hce_we_i(hwe),
    .hce_wdata_i(hwd), .hce_o(hce), .allow_o(allow), .illegal_o(illegal)
  );

  function automatic logic [1:0] model(logic [11:0] a, logic [1:0] p, logic v,
                                       logic [31:0] m, logic [31:0] s, logic [31:0] h);
    logic hit, ok;
    logic [4:0] i;
    hit = (a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F);
    i = a[4:0];
    if (!hit) return 2'b00;
    if (p == 2'd3) ok = 1'b1;
    else ok = m[i] && (!v || h[i]) && (p != 2'd0 || s[i]);
    return {ok, !ok};
  endfunction

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] p, input logic v,
                    input logic [31:0] m, input logic [31:0] s, input string tag);
    logic [1:0] e;
    @(negedge clk);
    csr_addr = a; priv = p; virt = v; mcnt = m; scnt = s;
    #1;
    e = model(a, p, v, m, s, hce_model);
    chk({allow, illegal} == e, tag, {30'b0, allow, illegal}, {30'b0, e});
  endtask

  task automatic wr(input logic [31:0] d, input logic we, input string tag);
    @(negedge clk);
    hwd = d; hwe = we;
    @(negedge clk);
    hwe = 1'b0; hwd = ~d;
    if (we) hce_model = d & ~MASK;
    #1;
    chk(hce == hce_model, tag, hce, hce_model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h1234_5678);
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    chk(hce == 32'h0, "R1 reset value", hce, 32'h0);
    rd(12'hC01, 2'd1, 1'b1, '1, '1, "R8 guest kernel with empty hce");

    wr(32'hFFFF_FFFF, 1'b1, "R2 write all ones masked");
    wr(32'h0000_0000, 1'b0, "R11 strobe low ignored");
    rd(12'hC1D, 2'd1, 1'b1, '1, '1, "R2 hardwired bit 29 traps guest");
    rd(12'hC00, 2'd3, 1'b1, '0, '0, "R4 machine ignores enables");
    rd(12'hC9F, 2'd3, 1'b0, '0, '0, "R4 machine high window top");
    rd(12'hC1F, 2'd1, 1'b0, 32'h7FFF_FFFF, '0, "R5 machine bit clear");
    rd(12'hC02, 2'd0, 1'b1, 32'hFFFF_FFFB, '1, "R5 guest user machine bit clear");
    rd(12'hC20, 2'd1, 1'b0, '1, '1, "R3 just above low window");
    rd(12'hBFF, 2'd1, 1'b0, '1, '1, "R3 just below low window");
    rd(12'hC7F, 2'd0, 1'b0, '1, '1, "R3 just below high window");
    rd(12'hCA0, 2'd3, 1'b0, '1, '1, "R3 just above high window");
    rd(12'hC83, 2'd1, 1'b0, 32'h0000_0008, '0, "R6 high window index 3");
    rd(12'hC83, 2'd2, 1'b0, 32'h0000_0008, '0, "R6 reserved priv as supervisor");
    rd(12'hC05, 2'd0, 1'b0, '1, 32'hFFFF_FFDF, "R7 user needs supervisor bit");
    rd(12'hC05, 2'd0, 1'b0, '1, 32'h0000_0020, "R7 user with both bits");
    wr(32'h0000_0002, 1'b1, "R2 single bit write");
    rd(12'hC01, 2'd1, 1'b1, '1, '0, "R8 guest kernel hce set");
    rd(12'hC01, 2'd0, 1'b1, '1, '0, "R9 guest user supervisor clear");
    rd(12'hC01, 2'd0, 1'b1, '1, 32'h2, "R9 guest user all set");
    rd(12'hC00, 2'd1, 1'b1, '1, '1, "R8 guest kernel hce clear");

    for (int n = 0; n < 800; n++) begin
      logic [11:0] a;
      int k;
      if (n % 50 == 0) wr($urandom, ($urandom % 4) != 0, "R2 R11 random write");
      k = $urandom % 6;
      case (k)
        0: a = 12'hC00 + 12'($urandom % 32);
        1: a = 12'hC80 + 12'($urandom % 32);
        2: a = 12'hC1C + 12'($urandom % 8);
        3: a = 12'hC7C + 12'($urandom % 8);
        4: a = 12'hC9C + 12'($urandom % 8);
        default: a = 12'($urandom);
      endcase
      rd(a, 2'($urandom), 1'($urandom), $urandom | $urandom, $urandom | $urandom,
         "R3 R4 R5 R6 R7 R8 R9 R10 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule